// File: doc/BRIEF.md
# DMA Burst Splitter

This block sits between a DMA channel's programmed transfer settings and the logic that drives a memory bus. It takes one burst request and breaks it into bus sub-bursts. The request carries a start address, a beat width code, a length code, an incrementing-or-fixed address flag and the depth of the channel FIFO in beats.

Every sub-burst it emits fits the channel FIFO. In incrementing mode, no sub-burst runs past a 1 KB address boundary. Each sub-burst is offered on a valid/ready handshake with its address, beat count and width code. When the last one is taken, a one-cycle completion pulse follows.

Some requests cannot be issued: an illegal width code, a start address not aligned to the beat width, or a FIFO depth of zero. These are refused with a one-cycle error pulse, and nothing is issued. The block takes a new request only while idle and captures the request fields at that moment.

Top module: `burst_splitter`

## Requirements
- R1: The length field holds beats minus one (0 to 63). The beat counts of all sub-bursts issued for one request add up to the field value plus one.
- R2: Width codes 0, 1 and 2 select 1, 2 and 4 bytes per beat, and `sub_width` carries the accepted code. Width code 3 is refused with an error, and nothing is issued.
- R3: A start address that is not a multiple of the beat size in bytes is refused with an error, and nothing is issued.
- R4: A FIFO depth of zero is refused with an error, and nothing is issued.
- R5: `err` is high for exactly one cycle, in the cycle after the refused request is accepted. The block stays idle.
- R6: In incrementing mode, no sub-burst crosses a 1 KB boundary. That is, `sub_addr` mod 1024 plus beats times beat size is at most 1024.
- R7: No sub-burst has more beats than the FIFO depth, and none has zero beats.
- R8: Each sub-burst has the largest beat count allowed. This is the minimum of the remaining beats, the FIFO depth and, in incrementing mode only, the beats left before the next 1 KB boundary.
- R9: In incrementing mode, each sub-burst starts at the previous sub-burst's address plus its beats times the beat size. In fixed mode, every sub-burst uses the start address.
- R10: In fixed mode, the 1 KB boundary never shortens a sub-burst.
- R11: While `sub_valid` is high and `sub_ready` is low, `sub_valid`, `sub_addr`, `sub_beats` and `sub_width` hold their values into the next cycle.
- R12: `done` is high for exactly one cycle, the cycle after the final sub-burst handshake. It is never high at any other time.
- R13: `req_ready` is high only while no sub-burst is pending. Request inputs that change while the block is busy have no effect on the sub-bursts issued or on `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when both high |
| req_addr | input | ADDR_W | Start byte address |
| req_width | input | 2 | Beat width code (log2 of bytes) |
| req_len_m1 | input | LEN_W | Beats minus one |
| req_incr | input | 1 | 1: incrementing address, 0: fixed address |
| req_fifo_beats | input | LEN_W+1 | Channel FIFO depth in beats |
| sub_valid | output | 1 | Sub-burst offered |
| sub_ready | input | 1 | Sub-burst taken when both high |
| sub_addr | output | ADDR_W | Sub-burst start address |
| sub_beats | output | LEN_W+1 | Sub-burst beat count (1 or more) |
| sub_width | output | 2 | Beat width code of the sub-burst |
| done | output | 1 | One-cycle pulse after the last sub-burst is taken |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
A wrong remaining-beat count first shows up in the beat count of the last sub-burst, or as an early or missing `done`. The bench catches it within the request where it happens, because it compares every handshake against an arithmetic model. A corrupted address register shows up in the next sub-burst's `sub_addr` and usually also in its beat count near a 1 KB boundary. So the error surfaces at the very next handshake. The sweeps use start offsets just below a boundary, FIFO depths from 1 to above the longest burst, and a stall pattern on `sub_ready`. Together these expose boundary, limit and hold faults within a few cycles.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } split_st_e;

    localparam int unsigned WCODE_W   = 2;
    localparam logic [1:0]  WCODE_BAD = 2'd3;
endpackage

// File: rtl/bsplit_validate.sv
module bsplit_validate
    import bsplit_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic [1:0]       addr_lo,
    input  logic [1:0]       width,
    input  logic [CNT_W-1:0] fifo_beats,
    output logic             ok
);
    logic misaligned;
    logic bad_code;
    logic no_fifo;

    always_comb begin
        bad_code   = (width == WCODE_BAD);
        misaligned = ((width == 2'd1) && addr_lo[0]) ||
                     ((width == 2'd2) && (addr_lo != 2'b00));
        no_fifo    = (fifo_beats == '0);
        ok         = !bad_code && !misaligned && !no_fifo;
    end
endmodule

// File: rtl/bsplit_chunk.sv
module bsplit_chunk #(
    parameter int unsigned CNT_W      = 7,
    parameter int unsigned BOUND_LOG2 = 10
) (
    input  logic [BOUND_LOG2-1:0] addr_off,
    input  logic [1:0]            width,
    input  logic [CNT_W-1:0]      remaining,
    input  logic [CNT_W-1:0]      fifo_beats,
    input  logic                  incr,
    output logic [CNT_W-1:0]      beats
);
    localparam int unsigned MW = (CNT_W > BOUND_LOG2 + 1) ? CNT_W : BOUND_LOG2 + 1;

    logic [MW-1:0] room_bytes;
    logic [MW-1:0] room_beats;
    logic [MW-1:0] lim_store;
    logic [MW-1:0] lim_all;

    always_comb begin
        room_bytes = (MW'(1) << BOUND_LOG2) - MW'(addr_off);
        room_beats = room_bytes >> width;
        lim_store  = (MW'(remaining) < MW'(fifo_beats)) ? MW'(remaining) : MW'(fifo_beats);
        lim_all    = (incr && (room_beats < lim_store)) ? room_beats : lim_store;
        beats      = CNT_W'(lim_all);
    end
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import bsplit_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 6,
    parameter int unsigned BOUND_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_width,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic              req_incr,
    input  logic [LEN_W:0]    req_fifo_beats,
    output logic              sub_valid,
    input  logic              sub_ready,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [LEN_W:0]    sub_beats,
    output logic [1:0]        sub_width,
    output logic              done,
    output logic              err
);
    localparam int unsigned CNT_W = LEN_W + 1;

    typedef struct packed {
        split_st_e         st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  rem;
        logic [1:0]        w;
        logic              incr;
        logic [CNT_W-1:0]  fifo;
        logic              done;
        logic              err;
    } split_state_t;

    split_state_t s_d, s_q;

    logic             req_ok;
    logic [CNT_W-1:0] chunk_beats;
    logic             cur_incr;
    logic [CNT_W-1:0] cur_fifo;

    bsplit_validate #(.CNT_W(CNT_W)) u_validate (
        .addr_lo    (req_addr[1:0]),
        .width      (req_width),
        .fifo_beats (req_fifo_beats),
        .ok         (req_ok)
    );

    bsplit_chunk #(.CNT_W(CNT_W), .BOUND_LOG2(BOUND_LOG2)) u_chunk (
        .addr_off   (s_q.addr[BOUND_LOG2-1:0]),
        .width      (s_q.w),
        .remaining  (s_q.rem),
        .fifo_beats (s_q.fifo),
        .incr       (s_q.incr),
        .beats      (chunk_beats)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_ok) begin
                        s_d.st   = ST_ISSUE;
                        s_d.addr = req_addr;
                        s_d.rem  = CNT_W'(req_len_m1) + CNT_W'(1);
                        s_d.w    = req_width;
                        s_d.incr = req_incr;
                        s_d.fifo = req_fifo_beats;
                    end else begin
                        s_d.err = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (sub_ready) begin
                    s_d.rem = s_q.rem - chunk_beats;
                    if (s_q.incr) begin
                        s_d.addr = s_q.addr + (ADDR_W'(chunk_beats) << s_q.w);
                    end
                    if (s_q.rem == chunk_beats) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, addr: '0, rem: '0, w: '0, incr: 1'b0,
                     fifo: '0, done: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign sub_valid = (s_q.st == ST_ISSUE);
    assign sub_addr  = s_q.addr;
    assign sub_beats = chunk_beats;
    assign sub_width = s_q.w;
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign cur_incr  = s_q.incr;
    assign cur_fifo  = s_q.fifo;
endmodule

// File: rtl/burst_splitter_chk.sv
module burst_splitter_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 7,
    parameter int unsigned BOUND_LOG2 = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              sub_valid,
    input logic              sub_ready,
    input logic [ADDR_W-1:0] sub_addr,
    input logic [CNT_W-1:0]  sub_beats,
    input logic [1:0]        sub_width,
    input logic              done,
    input logic              err,
    input logic              cur_incr,
    input logic [CNT_W-1:0]  cur_fifo
);
    localparam int unsigned EW = BOUND_LOG2 + CNT_W + 3;

    logic [EW-1:0] end_off;
    assign end_off = EW'(sub_addr[BOUND_LOG2-1:0]) + (EW'(sub_beats) << sub_width);

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && cur_incr) |-> (end_off <= (EW'(1) << BOUND_LOG2))); // R6

    AST_FIFO_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> ((sub_beats <= cur_fifo) && (sub_beats != '0))); // R7

    AST_LEGAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> ((sub_width != 2'd3) &&
                       ((sub_width == 2'd0) ||
                        ((sub_width == 2'd1) && !sub_addr[0]) ||
                        ((sub_width == 2'd2) && (sub_addr[1:0] == 2'b00))))); // R2

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> sub_valid); // R11

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> $stable(sub_addr)); // R11

    AST_HOLD_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ready) |=> ($stable(sub_beats) && $stable(sub_width))); // R11

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sub_valid && sub_ready)); // R12

    AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(req_valid && req_ready) && !sub_valid)); // R5

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && sub_valid)); // R13
endmodule

bind burst_splitter burst_splitter_chk #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (LEN_W + 1),
    .BOUND_LOG2 (BOUND_LOG2)
) u_split_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sub_valid (sub_valid),
    .sub_ready (sub_ready),
    .sub_addr  (sub_addr),
    .sub_beats (sub_beats),
    .sub_width (sub_width),
    .done      (done),
    .err       (err),
    .cur_incr  (cur_incr),
    .cur_fifo  (cur_fifo)
);

// File: tb/tb_burst_splitter.sv
module tb_burst_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_width = '0;
    logic [5:0]  req_len_m1 = '0;
    logic        req_incr = 1'b0;
    logic [6:0]  req_fifo_beats = '0;
    logic        sub_valid;
    logic        sub_ready = 1'b0;
    logic [31:0] sub_addr;
    logic [6:0]  sub_beats;
    logic [1:0]  sub_width;
    logic        done;
    logic        err;

    int n_tests = 0;
    int n_fail  = 0;
    int stall_cnt = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    burst_splitter dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_width(req_width), .req_len_m1(req_len_m1),
        .req_incr(req_incr), .req_fifo_beats(req_fifo_beats),
        .sub_valid(sub_valid), .sub_ready(sub_ready),
        .sub_addr(sub_addr), .sub_beats(sub_beats), .sub_width(sub_width),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 190000", cycles);
            finish_run();
        end
    end

    task automatic do_req(input logic [31:0] a, input int w, input int len,
                          input bit inc, input int ff, input string tag);
        bit legal;
        int rem;
        int lim;
        int room;
        int subs;
        logic [31:0] ea;
        legal = (w != 3) && ((a % (32'd1 << w)) == 0) && (ff != 0);
        req_valid      = 1'b1;
        req_addr       = a;
        req_width      = 2'(w);
        req_len_m1     = 6'(len);
        req_incr       = inc;
        req_fifo_beats = 7'(ff);
        check(req_ready == 1'b1, "R13", "ready before request", req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        // junk on the request side while busy: R13
        req_valid  = 1'b1;
        req_width  = 2'd3;
        req_addr   = 32'hFFFF_FFFF;
        req_fifo_beats = 7'd0;
        req_len_m1 = 6'd0;
        if (!legal) begin
            check(err == 1'b1 && sub_valid == 1'b0, tag, "refused request err", err, 1);
            req_valid = 1'b0;
            @(posedge clk);
            @(negedge clk);
            check(err == 1'b0, "R5", "err one cycle", err, 0);
            check(sub_valid == 1'b0 && req_ready == 1'b1, "R5", "idle after refuse", sub_valid, 0);
            return;
        end
        check(err == 1'b0 && req_ready == 1'b0, "R13", "busy no err", {err, req_ready}, 0);
        rem  = len + 1;
        ea   = a;
        subs = 0;
        while (rem > 0 && !finished) begin
            if (!sub_valid) begin
                check(1'b0, "R1", "sub_valid missing with beats left", rem, 0);
                break;
            end
            stall_cnt++;
            sub_ready = (stall_cnt % 3) != 1;
            lim = (rem < ff) ? rem : ff;
            if (inc) begin
                room = (1024 - int'(ea % 1024)) >> w;
                if (room < lim) lim = room;
            end
            if (sub_ready) begin
                check(sub_addr == ea, inc ? "R9" : "R10", "sub_addr", sub_addr, ea);
                check(int'(sub_beats) == lim, inc ? "R8" : "R10", "sub_beats", sub_beats, lim);
                check(int'(sub_width) == w, "R2", "sub_width", sub_width, w);
                check(done == 1'b0, "R12", "done early", done, 0);
            end
            @(posedge clk);
            @(negedge clk);
            if (sub_ready) begin
                rem -= lim;
                subs++;
                if (inc) ea += 32'(lim) << w;
            end
        end
        sub_ready = 1'b0;
        check(rem == 0, "R1", "total beats", rem, 0);
        check(done == 1'b1 && sub_valid == 1'b0 && req_ready == 1'b1, "R12",
              "done after last", {done, sub_valid, req_ready}, 3'b101);
        check(err == 1'b0, "R13", "junk ignored while busy", err, 0);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0 && err == 1'b0, "R12", "done one cycle", done, 0);
    endtask

    initial begin
        int lens[6]  = '{0, 1, 3, 7, 16, 63};
        int offs[5]  = '{0, 'h3C0, 'h3F8, 'h3FC, 'h204};
        int fifos[4] = '{1, 5, 16, 64};
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && sub_valid == 1'b0 && done == 1'b0 && err == 1'b0,
              "R13", "reset state", {req_ready, sub_valid, done, err}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int w = 0; w < 3; w++)
            for (int li = 0; li < 6; li++)
                for (int oi = 0; oi < 5; oi++)
                    for (int fi = 0; fi < 4; fi++)
                        for (int inc = 0; inc < 2; inc++)
                            do_req(32'h2000_0000 + 32'(offs[oi]), w, lens[li], inc[0],
                                   fifos[fi], "R8");
        // FIFO deeper than the longest burst: R7
        do_req(32'h2000_03F0, 2, 63, 1'b1, 100, "R7");
        do_req(32'h2000_03F0, 2, 63, 1'b0, 100, "R10");
        // refused settings
        do_req(32'h2000_0000, 3, 4, 1'b1, 16, "R2");
        do_req(32'h2000_0001, 1, 4, 1'b1, 16, "R3");
        do_req(32'h2000_0002, 2, 4, 1'b1, 16, "R3");
        do_req(32'h2000_0003, 2, 4, 1'b0, 16, "R3");
        do_req(32'h2000_0000, 0, 4, 1'b1, 0, "R4");
        // back-to-back after a refusal
        do_req(32'h2000_0100, 0, 10, 1'b1, 4, "R1");
        finish_run();
    end
endmodule